// File: doc/BRIEF.md
# Codec Link Frame Receiver

This block watches a serial audio-codec link from the side. It sees a frame-sync line, a bit clock and the two data lines: controller-to-codec (outbound) and codec-to-controller (inbound). It takes all four into a faster system clock. On each falling edge of the bit clock it takes one bit from each data line, shifts it in MSB first, and cuts both streams into the slots of a 256-bit frame. The first slot is a 16-bit tag and the other twelve slots are 20 bits each.

Each slot is reported on the cycle after its last bit arrives, as a one-cycle strobe per direction. The strobe carries the slot index and the decoded fields. The tag of each direction holds a valid mask, and that mask decides which later slots of the same direction are reported. Slot 1 carries the command or status address and slot 2 carries the command or status data; both are decoded field by field. Nonzero reserved bits and odd register addresses are flagged. Slots 3 to 12 are reported as 16-bit samples.

Top module: `aclink_frame_rx`

## Requirements
- R1: A frame starts on the bit sampled at a falling edge when the sync sample at the previous falling edge was 1 and the sync sample two falling edges back was 0; that bit is frame bit 0. From reset until the first such start, no strobe is raised and all outputs stay 0.
- R2: Slot 0 of each direction is 16 bits: ready (first bit), 12 valid bits (the first of them is for slot 1), one reserved bit, then a 2-bit codec id. Slot 0 is always reported in both directions with value = {ready, 13 zeros, codec id} and aux = the 12 valid bits, with aux bit 11 for slot 1 and aux bit 0 for slot 12.
- R3: A 1 in the reserved bit of slot 0 sets rsvErr on that slot 0 strobe.
- R4: Slot n (n = 1..12) is reported in a direction only if aux bit 12−n of that direction's slot 0 in the same frame was 1.
- R5: Outbound slot 1 (direction index 0) has a read flag (first bit, 1 = read), a 7-bit address, then 12 reserved bits. It reports value[6:0] = address and aux[0] = read flag. rsvErr is set if any of the 12 reserved bits is nonzero.
- R6: Inbound slot 1 (direction index 1) has a reserved lead bit, a 7-bit address, 10 request bits and 2 reserved bits. It reports value[6:0] = address and aux[9:0] = request bits. rsvErr is set if the lead bit or either trailing bit is nonzero.
- R7: addrErr is set on a slot 1 strobe of either direction when the address is odd. It is never set on a strobe of any other slot.
- R8: Slot 2 reports value = its first 16 bits. rsvErr is set if any of its last 4 bits is nonzero.
- R9: Slots 3 to 12 report value = the upper 16 bits of the 20-bit slot, with aux = 0 and no error flags.
- R10: After the 256th bit of a frame, bits are ignored and no strobe is raised until the next frame start.
- R11: A new frame start in the middle of a frame restarts bit counting at frame bit 0.
- R12: Every slot is shifted in MSB first. Data and sync are taken only at falling edges of the bit clock. A slot's strobe comes after its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Frame sync line from the link |
| bitClkIn | input | 1 | Link bit clock |
| sdoIn | input | 1 | Outbound serial data (controller to codec) |
| sdiIn | input | 1 | Inbound serial data (codec to controller) |
| slotStb | output | 2 | Per-direction slot strobe; index 0 outbound, 1 inbound |
| slotIdx | output | 2x4 | Slot number 0..12 per direction |
| slotValue | output | 2x16 | Decoded value per direction |
| slotAux | output | 2x12 | Valid mask, read flag or request bits per direction |
| rsvErr | output | 2 | Reserved bits nonzero in the reported slot |
| addrErr | output | 2 | Odd register address in the reported slot 1 |

## Verification
The checks assume that each high phase and each low phase of the bit clock lasts at least three system clocks, so that no edge is lost in the synchronizer. They also assume that sync and data do not change near a falling edge. The stimulus holds each bit-clock phase for four system clocks and changes sync and data only just after a rising edge. With that spacing, the strobe ordering and alignment checks can rely on every link bit being sampled exactly once.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;
  localparam int unsigned SLOT_IDX_W = 4;
  localparam int unsigned DIR_OUT    = 0;
  localparam int unsigned DIR_IN     = 1;

  // Strobes from the control path to the datapath, all valid for one cycle.
  typedef struct packed {
    logic                  frameStart;
    logic                  bitEn;
    logic                  slotEnd;
    logic [SLOT_IDX_W-1:0] slotIdx;
  } rxCtl_t;
endpackage

// File: rtl/aclink_rx_sync.sv
module aclink_rx_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipe <= '0;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/aclink_rx_ctrl.sv
module aclink_rx_ctrl
  import aclink_rx_pkg::*;
#(
  parameter int unsigned SLOT0_BITS = 16,
  parameter int unsigned SLOT_BITS  = 20,
  parameter int unsigned NUM_SLOTS  = 13
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bclkS,
  input  logic   syncS,
  output rxCtl_t ctl
);
  localparam int unsigned CNT_W = $clog2(SLOT_BITS + 1);
  localparam logic [CNT_W-1:0]      FIRST_LEFT = CNT_W'(SLOT0_BITS - 1);
  localparam logic [CNT_W-1:0]      NEXT_LEFT  = CNT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_IDX_W-1:0] LAST_SLOT  = SLOT_IDX_W'(NUM_SLOTS - 1);

  logic                  bclkPrev;
  logic                  syncPrev1;  // sample at the previous falling edge
  logic                  syncPrev2;  // sample two falling edges back
  logic                  active;
  logic [SLOT_IDX_W-1:0] slotCur;
  logic [CNT_W-1:0]      bitsLeft;

  logic                  fallEdge;
  logic                  startNow;
  logic                  takeBit;
  logic                  slotDone;
  logic [SLOT_IDX_W-1:0] slotNow;
  logic [CNT_W-1:0]      leftNow;

  always_comb begin
    fallEdge = bclkPrev & ~bclkS;
    startNow = fallEdge & syncPrev1 & ~syncPrev2;
    takeBit  = fallEdge & (startNow | active);
    slotNow  = startNow ? '0 : slotCur;
    leftNow  = startNow ? FIRST_LEFT : bitsLeft;
    slotDone = takeBit && (leftNow == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkPrev  <= 1'b0;
      syncPrev1 <= 1'b0;
      syncPrev2 <= 1'b0;
      active    <= 1'b0;
      slotCur   <= '0;
      bitsLeft  <= '0;
    end else begin
      bclkPrev <= bclkS;
      if (fallEdge) begin
        syncPrev2 <= syncPrev1;
        syncPrev1 <= syncS;
      end
      if (takeBit) begin
        active <= 1'b1;
        if (slotDone) begin
          if (slotNow == LAST_SLOT) begin
            active <= 1'b0;
          end else begin
            slotCur  <= slotNow + 1'b1;
            bitsLeft <= NEXT_LEFT;
          end
        end else begin
          slotCur  <= slotNow;
          bitsLeft <= leftNow - 1'b1;
        end
      end
    end
  end

  assign ctl.frameStart = startNow;
  assign ctl.bitEn      = takeBit;
  assign ctl.slotEnd    = slotDone;
  assign ctl.slotIdx    = slotNow;
endmodule

// File: rtl/aclink_rx_dpath.sv
module aclink_rx_dpath
  import aclink_rx_pkg::*;
#(
  parameter int unsigned SLOT0_BITS  = 16,
  parameter int unsigned SLOT_BITS   = 20,
  parameter int unsigned NUM_SLOTS   = 13,
  parameter int unsigned SAMPLE_BITS = 16,
  localparam int unsigned AUX_W      = NUM_SLOTS - 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  rxCtl_t                           ctl,
  input  logic [1:0]                       dataS,
  output logic [1:0]                       slotStb,
  output logic [1:0][SLOT_IDX_W-1:0]       slotIdx,
  output logic [1:0][SAMPLE_BITS-1:0]      slotValue,
  output logic [1:0][AUX_W-1:0]            slotAux,
  output logic [1:0]                       rsvErr,
  output logic [1:0]                       addrErr
);
  // Field positions inside the assembled slot word (LSB = last bit in).
  localparam int unsigned TAG_READY = SLOT0_BITS - 1;
  localparam int unsigned TAG_MASK_HI = SLOT0_BITS - 2;
  localparam int unsigned TAG_MASK_LO = SLOT0_BITS - 1 - AUX_W;
  localparam int unsigned TAG_RSV   = TAG_MASK_LO - 1;
  localparam int unsigned ADDR_W    = 7;
  localparam int unsigned ADDR_HI   = SLOT_BITS - 2;
  localparam int unsigned ADDR_LO   = SLOT_BITS - 1 - ADDR_W;
  localparam int unsigned REQ_W     = 10;
  localparam int unsigned DATA_RSV_W = SLOT_BITS - SAMPLE_BITS;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [SLOT_BITS-2:0]  shReg;
    logic [SLOT_BITS-1:0]  word;
    logic [AUX_W-1:0]      validMask;
    logic [NUM_SLOTS-1:0]  enVec;
    logic [AUX_W-1:0]      s1Aux;
    logic                  s1Rsv;
    logic [SAMPLE_BITS-1:0] nVal;
    logic [AUX_W-1:0]      nAux;
    logic                  nRsv;
    logic                  nAddr;
    logic                  stbQ;
    logic [SLOT_IDX_W-1:0] idxQ;
    logic [SAMPLE_BITS-1:0] valQ;
    logic [AUX_W-1:0]      auxQ;
    logic                  rsvQ;
    logic                  addrQ;

    assign word = {shReg, dataS[d]};

    // Slot enable vector: slot 0 always, slot n from mask bit AUX_W-n.
    assign enVec[0] = 1'b1;
    for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_en
      assign enVec[s] = validMask[AUX_W-s];
    end

    if (d == DIR_OUT) begin : g_cmd
      assign s1Aux = AUX_W'(word[SLOT_BITS-1]);
      assign s1Rsv = |word[ADDR_LO-1:0];
    end else begin : g_sts
      assign s1Aux = AUX_W'(word[ADDR_LO-1 -: REQ_W]);
      assign s1Rsv = word[SLOT_BITS-1] | (|word[ADDR_LO-1-REQ_W:0]);
    end

    always_comb begin
      nVal  = '0;
      nAux  = '0;
      nRsv  = 1'b0;
      nAddr = 1'b0;
      if (ctl.slotIdx == SLOT_IDX_W'(0)) begin
        nVal  = {word[TAG_READY], {(SAMPLE_BITS-3){1'b0}}, word[1:0]};
        nAux  = word[TAG_MASK_HI:TAG_MASK_LO];
        nRsv  = word[TAG_RSV];
      end else if (ctl.slotIdx == SLOT_IDX_W'(1)) begin
        nVal  = SAMPLE_BITS'(word[ADDR_HI:ADDR_LO]);
        nAux  = s1Aux;
        nRsv  = s1Rsv;
        nAddr = word[ADDR_LO];
      end else begin
        nVal = word[SLOT_BITS-1 -: SAMPLE_BITS];
        if (ctl.slotIdx == SLOT_IDX_W'(2)) nRsv = |word[DATA_RSV_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shReg     <= '0;
        validMask <= '0;
        stbQ      <= 1'b0;
        idxQ      <= '0;
        valQ      <= '0;
        auxQ      <= '0;
        rsvQ      <= 1'b0;
        addrQ     <= 1'b0;
      end else begin
        stbQ <= 1'b0;
        if (ctl.bitEn) shReg <= word[SLOT_BITS-2:0];
        if (ctl.frameStart) validMask <= '0;
        if (ctl.slotEnd) begin
          if (ctl.slotIdx == SLOT_IDX_W'(0)) validMask <= word[TAG_MASK_HI:TAG_MASK_LO];
          if (enVec[ctl.slotIdx]) begin
            stbQ  <= 1'b1;
            idxQ  <= ctl.slotIdx;
            valQ  <= nVal;
            auxQ  <= nAux;
            rsvQ  <= nRsv;
            addrQ <= nAddr;
          end
        end
      end
    end

    assign slotStb[d]   = stbQ;
    assign slotIdx[d]   = idxQ;
    assign slotValue[d] = valQ;
    assign slotAux[d]   = auxQ;
    assign rsvErr[d]    = rsvQ;
    assign addrErr[d]   = addrQ;
  end
endmodule

// File: rtl/aclink_frame_rx.sv
module aclink_frame_rx
  import aclink_rx_pkg::*;
#(
  parameter int unsigned SLOT0_BITS  = 16,
  parameter int unsigned SLOT_BITS   = 20,
  parameter int unsigned NUM_SLOTS   = 13,
  parameter int unsigned SAMPLE_BITS = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AUX_W      = NUM_SLOTS - 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        syncIn,
  input  logic                        bitClkIn,
  input  logic                        sdoIn,
  input  logic                        sdiIn,
  output logic [1:0]                  slotStb,
  output logic [1:0][SLOT_IDX_W-1:0]  slotIdx,
  output logic [1:0][SAMPLE_BITS-1:0] slotValue,
  output logic [1:0][AUX_W-1:0]       slotAux,
  output logic [1:0]                  rsvErr,
  output logic [1:0]                  addrErr
);
  logic [3:0] pinsS;
  rxCtl_t     ctl;

  aclink_rx_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({bitClkIn, syncIn, sdiIn, sdoIn}),
    .dout (pinsS)
  );

  aclink_rx_ctrl #(
    .SLOT0_BITS (SLOT0_BITS),
    .SLOT_BITS  (SLOT_BITS),
    .NUM_SLOTS  (NUM_SLOTS)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .bclkS (pinsS[3]),
    .syncS (pinsS[2]),
    .ctl   (ctl)
  );

  aclink_rx_dpath #(
    .SLOT0_BITS  (SLOT0_BITS),
    .SLOT_BITS   (SLOT_BITS),
    .NUM_SLOTS   (NUM_SLOTS),
    .SAMPLE_BITS (SAMPLE_BITS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .dataS     (pinsS[1:0]),
    .slotStb   (slotStb),
    .slotIdx   (slotIdx),
    .slotValue (slotValue),
    .slotAux   (slotAux),
    .rsvErr    (rsvErr),
    .addrErr   (addrErr)
  );
endmodule

// File: rtl/aclink_rx_checker.sv
module aclink_rx_checker
  import aclink_rx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 13,
  localparam int unsigned AUX_W    = NUM_SLOTS - 1
) (
  input logic                       clk,
  input logic                       rstN,
  input rxCtl_t                     ctl,
  input logic [1:0]                 slotStb,
  input logic [1:0][SLOT_IDX_W-1:0] slotIdx,
  input logic [1:0][AUX_W-1:0]      slotAux,
  input logic [1:0]                 addrErr
);
  logic seenStart;

  always_ff @(posedge clk) begin
    if (!rstN) seenStart <= 1'b0;
    else if (ctl.frameStart) seenStart <= 1'b1;
  end

  // R1: quiet until the first frame start
  a_r1_quiet_before_start: assert property (@(posedge clk) disable iff (!rstN)
    !seenStart |-> slotStb == 2'b00);

  // R2: tag slot end yields a strobe in both directions
  a_r2_tag_both_dirs: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.slotEnd && ctl.slotIdx == '0) |=> (slotStb == 2'b11 && slotIdx[0] == '0 && slotIdx[1] == '0));

  for (genvar d = 0; d < 2; d++) begin : g_chk
    // R12: a strobe follows the control's slot end for the same slot
    a_r12_stb_after_end: assert property (@(posedge clk) disable iff (!rstN)
      slotStb[d] |-> ($past(ctl.slotEnd) && slotIdx[d] == $past(ctl.slotIdx)));

    // R10: never beyond the last slot
    a_r10_idx_range: assert property (@(posedge clk) disable iff (!rstN)
      slotStb[d] |-> slotIdx[d] <= SLOT_IDX_W'(NUM_SLOTS - 1));

    // R7: address error only on slot 1
    a_r7_addr_err_slot1: assert property (@(posedge clk) disable iff (!rstN)
      (slotStb[d] && slotIdx[d] != SLOT_IDX_W'(1)) |-> !addrErr[d]);

    // R9: no side field on data and sample slots
    a_r9_aux_zero: assert property (@(posedge clk) disable iff (!rstN)
      (slotStb[d] && slotIdx[d] >= SLOT_IDX_W'(2)) |-> slotAux[d] == '0);
  end
endmodule

bind aclink_frame_rx aclink_rx_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ctl     (ctl),
  .slotStb (slotStb),
  .slotIdx (slotIdx),
  .slotAux (slotAux),
  .addrErr (addrErr)
);

// File: tb/aclink_frame_rx_tb_top.sv
`timescale 1ns/1ps
module aclink_frame_rx_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncIn = 1'b0, bitClkIn = 1'b0, sdoIn = 1'b0, sdiIn = 1'b0;
  logic [1:0]        slotStb;
  logic [1:0][3:0]   slotIdx;
  logic [1:0][15:0]  slotValue;
  logic [1:0][11:0]  slotAux;
  logic [1:0]        rsvErr;
  logic [1:0]        addrErr;

  int nChecks = 0;
  int nFails  = 0;

  logic [19:0] wOut [13];
  logic [19:0] wIn  [13];
  logic [255:0] frameOut, frameIn;

  logic [39:0] rec [512];
  int recN = 0;
  logic [39:0] expv [128];
  int expN = 0;

  always #4 clk = ~clk;

  aclink_frame_rx dut_i (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .bitClkIn(bitClkIn),
    .sdoIn(sdoIn), .sdiIn(sdiIn), .slotStb(slotStb), .slotIdx(slotIdx),
    .slotValue(slotValue), .slotAux(slotAux), .rsvErr(rsvErr), .addrErr(addrErr)
  );

  function automatic logic [39:0] mk(input logic d, input logic [3:0] s, input logic [15:0] v,
                                     input logic [11:0] a, input logic r, input logic ad);
    return {5'b0, d, s, v, a, r, ad};
  endfunction

  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (slotStb[d] && recN < 512) begin
        rec[recN] = mk(d[0], slotIdx[d], slotValue[d], slotAux[d], rsvErr[d], addrErr[d]);
        recN = recN + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] want);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, want);
    end
  endtask

  task automatic sendBit(input logic s, input logic o, input logic i);
    syncIn = s; sdoIn = o; sdiIn = i; bitClkIn = 1'b1;
    repeat (4) @(posedge clk); #1;
    bitClkIn = 1'b0;
    repeat (4) @(posedge clk); #1;
  endtask

  // Preamble (sync 0 then 1), then nBits of the frame; sync high for bits 0..14.
  task automatic sendFrame(input int nBits);
    frameOut = '0; frameIn = '0;
    frameOut[255 -: 16] = wOut[0][15:0];
    frameIn[255 -: 16]  = wIn[0][15:0];
    for (int s = 1; s < 13; s++) begin
      frameOut[239 - 20*(s-1) -: 20] = wOut[s];
      frameIn[239 - 20*(s-1) -: 20]  = wIn[s];
    end
    sendBit(1'b0, 1'b0, 1'b0);
    sendBit(1'b1, 1'b1, 1'b1);
    for (int b = 0; b < nBits; b++) sendBit(b < 15, frameOut[255-b], frameIn[255-b]);
  endtask

  task automatic sendIdle(input int n);
    for (int b = 0; b < n; b++) sendBit(1'b0, b[0], ~b[1]);
  endtask

  // Expected strobes from the requirements, appended in slot order, outbound first.
  task automatic buildExpected(input int nBits);
    for (int s = 0; s < 13; s++) begin
      int endBit;
      endBit = (s == 0) ? 15 : 15 + 20*s;
      if (endBit < nBits) begin
        for (int d = 0; d < 2; d++) begin
          logic [19:0] w;
          logic [11:0] m;
          logic [15:0] v;
          logic [11:0] a;
          logic r, ad;
          w = d ? wIn[s] : wOut[s];
          m = d ? wIn[0][14:3] : wOut[0][14:3];
          v = '0; a = '0; r = 1'b0; ad = 1'b0;
          if (s == 0) begin
            v = {w[15], 13'b0, w[1:0]}; a = m; r = w[2];
          end else if (s == 1) begin
            v = {9'b0, w[18:12]}; ad = w[12];
            if (d == 0) begin a = {11'b0, w[19]}; r = |w[11:0]; end
            else begin a = {2'b0, w[11:2]}; r = w[19] | (|w[1:0]); end
          end else begin
            v = w[19:4];
            if (s == 2) r = |w[3:0];
          end
          if (s == 0 || m[12-s]) begin
            expv[expN] = mk(d[0], 4'(s), v, a, r, ad);
            expN++;
          end
        end
      end
    end
  endtask

  function automatic string tagFor(input logic [39:0] e);
    logic [3:0] s;
    s = e[33:30];
    if (s == 0) return "R2 R3 R12";
    if (s == 1) return e[34] ? "R6 R7" : "R5 R7";
    if (s == 2) return "R8";
    return "R9";
  endfunction

  task automatic compareFrom(input int base, input string cntTag);
    check(recN - base == expN, cntTag, 64'(recN - base), 64'(expN));
    for (int i = 0; i < expN; i++) begin
      if (base + i < recN)
        check(rec[base+i] == expv[i], tagFor(expv[i]), 64'(rec[base+i]), 64'(expv[i]));
    end
  endtask

  task automatic fillSlots(input logic [11:0] mOut, input logic [11:0] mIn);
    wOut[0] = {4'h0, 1'b1, mOut, 1'b0, 2'b10};
    wIn[0]  = {4'h0, 1'b0, mIn, 1'b0, 2'b01};
    wOut[1] = {1'b1, 7'h26, 12'h000};
    wIn[1]  = {1'b0, 7'h3A, 10'h2A5, 2'b00};
    wOut[2] = {16'hBEEF, 4'h0};
    wIn[2]  = {16'h1234, 4'h0};
    for (int s = 3; s < 13; s++) begin
      wOut[s] = 20'(32'h13579 * s);
      wIn[s]  = 20'(32'h2468A * s + 7);
    end
  endtask

  task automatic t_reset_quiet();
    int base;
    check(slotStb == 2'b00 && slotValue == '0 && slotAux == '0 && rsvErr == 2'b00,
          "R1 reset state", 64'(slotStb), 64'(0));
    base = recN;
    sendIdle(40);
    check(recN == base, "R1 no strobe before start", 64'(recN - base), 64'(0));
  endtask

  task automatic t_full_valid();
    int base;
    base = recN; expN = 0;
    fillSlots(12'hFFF, 12'hFFF);
    buildExpected(256);
    sendFrame(256);
    sendIdle(2);
    compareFrom(base, "R2 R12 count");
  endtask

  task automatic t_masks();
    int base;
    base = recN; expN = 0;
    fillSlots(12'b1010_0000_0101, 12'b0101_0011_0000);
    buildExpected(256);
    sendFrame(256);
    sendIdle(2);
    compareFrom(base, "R4 count");
  endtask

  task automatic t_errors();
    int base;
    base = recN; expN = 0;
    fillSlots(12'hFFF, 12'hFFF);
    wOut[0][2] = 1'b1;
    wIn[0][2]  = 1'b1;
    wOut[1] = {1'b0, 7'h27, 12'h801};
    wIn[1]  = {1'b1, 7'h11, 10'h000, 2'b10};
    wOut[2] = {16'h0F0F, 4'h9};
    wIn[2]  = {16'hFFFF, 4'h0};
    buildExpected(256);
    sendFrame(256);
    sendIdle(2);
    compareFrom(base, "R3 R7 count");
  endtask

  task automatic t_trailing();
    int base;
    base = recN; expN = 0;
    fillSlots(12'hC03, 12'h3C0);
    buildExpected(256);
    sendFrame(256);
    sendIdle(60);
    compareFrom(base, "R10 trailing bits ignored");
  endtask

  task automatic t_restart();
    int base;
    base = recN; expN = 0;
    fillSlots(12'hFFF, 12'hF0F);
    buildExpected(100);
    sendFrame(100);
    fillSlots(12'h5A5, 12'hFFF);
    wOut[2] = {16'hCAFE, 4'h0};
    buildExpected(256);
    sendFrame(256);
    sendIdle(2);
    compareFrom(base, "R11 restart count");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1 watchdog", 64'(0), 64'(1));
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk); #1;
    rstN = 1'b1;
    repeat (3) @(posedge clk); #1;
    t_reset_quiet();
    t_full_valid();
    t_masks();
    t_errors();
    t_trailing();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule